// File: doc/BRIEF.md
# Card Host Control Register with Self-Clearing Commands

This block is the main control register of a card host controller. Software writes it through a plain bus-slave port and can read it back at any time. Two of its bits are ordinary levels: a global interrupt enable and a read-wait request toward the card. Four bits are one-shot commands. Software sets a command by writing 1. The bit then stays set until its own completion condition clears it, so software polls the register to see when the command has finished.

The completion conditions differ per command. The DMA-interface reset clears after a fixed hold of bus clocks. The interrupt-mode response clears when the command engine reports that the response went out. The read abort clears when the data engine reports it is idle again. The completion-signal-disable request counts card-clock ticks and then drives the pattern. It clears when the engine reports the pattern sent, and at that moment it posts a command-done status pulse.

The single interrupt output combines the global enable with the externally held interrupt status and mask.

Top module: `hcCtrlReg`

## Requirements
- R1: After reset every register bit reads 0 and every output is 0.
- R2: Writing 1 to bit 2 sets it and raises `dmaRstOut`. Both stay 1 for exactly two clock cycles and then clear without any further write.
- R3: `irqOut` is 1 exactly when bit 4 is 1 and at least one bit of `intPending & intUnmask` is 1. The output is combinational on those inputs.
- R4: Bit 6 is a plain level that follows each write and drives `readWaitOut`. It never clears by itself.
- R5: Writing 1 to bit 7 sets it and `irqRespReq`. The bit clears at the first clock edge where `irqRespDone` is sampled 1 while it is set.
- R6: Writing 1 to bit 8 sets it and `abortReq`. The bit clears at the first clock edge where `dataIdle` is sampled 1 while it is set.
- R7: Writing 1 to bit 9 sets it. At the edge where `ccsdSent` is sampled 1 while it is set, the bit clears and `cmdDoneSet` is 1 for exactly the following cycle.
- R8: While bit 9 is set, `ccsdDrive` rises at the edge that samples the second `cardClkEn` tick counted since the bit was set. It stays 1 until the bit clears.
- R9: Writing 0 to a command bit (2, 7, 8, 9) changes nothing. Writing 1 to a command bit that is still set is ignored: it does not restart the DMA hold count.
- R10: Bits 0, 1, 3, 5 and 10 and above always read 0, whatever is written.
- R11: `irqRespDone`, `dataIdle` and `ccsdSent` have no effect while their command bit is clear. In particular, no `cmdDoneSet` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Live register contents |
| intPending | input | NUM_INT | Raw interrupt status bits |
| intUnmask | input | NUM_INT | 1 = status bit allowed to interrupt |
| irqOut | output | 1 | Interrupt output |
| dmaRstOut | output | 1 | DMA interface reset |
| readWaitOut | output | 1 | Read-wait request toward the card |
| irqRespReq | output | 1 | Request to command engine: send interrupt response |
| irqRespDone | input | 1 | Command engine: response sent |
| abortReq | output | 1 | Request to data engine: abort read |
| dataIdle | input | 1 | Data engine is idle |
| cardClkEn | input | 1 | One-cycle tick per card clock |
| ccsdDrive | output | 1 | Drive completion-signal-disable pattern |
| ccsdSent | input | 1 | Engine: pattern sent |
| cmdDoneSet | output | 1 | One-cycle command-done status post |

## Verification
The properties assume that the engine handshake inputs may arrive at any cycle, including while their command is idle. They also assume that `cardClkEn` is a single-cycle tick at most once per bus clock. They assume nothing about the order of writes relative to the handshakes. The stimulus changes every input only on the falling clock edge. It returns the handshake pulses and ticks to 0 after each cycle, and it deliberately raises stray handshakes while commands are idle and rewrites pending commands. This exercises the ignore paths within those assumptions.

// File: rtl/hcCtrlPkg.sv
package hcCtrlPkg;
  localparam int DMA_BIT    = 2;
  localparam int INTEN_BIT  = 4;
  localparam int RDWAIT_BIT = 6;
  localparam int IRQRSP_BIT = 7;
  localparam int ABORT_BIT  = 8;
  localparam int CCSD_BIT   = 9;

  typedef struct packed {
    logic lvlWr;
    logic intEnVal;
    logic rdWaitVal;
    logic setDma;
    logic setIrqRsp;
    logic setAbort;
    logic setCcsd;
    logic clrIrqRsp;
    logic clrAbort;
    logic clrCcsd;
  } ctrlStrobeT;

  typedef struct packed {
    logic dma;
    logic irqRsp;
    logic abort;
    logic ccsd;
  } cmdStateT;
endpackage

// File: rtl/hcCtrlDecode.sv
module hcCtrlDecode
  import hcCtrlPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  cmdStateT          cmdState,
  input  logic              irqRespDone,
  input  logic              dataIdle,
  input  logic              ccsdSent,
  output ctrlStrobeT        strobe
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << DMA_BIT) | (DATA_W'(1) << INTEN_BIT) | (DATA_W'(1) << RDWAIT_BIT) |
    (DATA_W'(1) << IRQRSP_BIT) | (DATA_W'(1) << ABORT_BIT) | (DATA_W'(1) << CCSD_BIT);

  logic unusedWr;
  assign unusedWr = ^(wrData & ~IMPL_MASK);

  always_comb begin
    strobe           = '0;
    strobe.lvlWr     = wrEn;
    strobe.intEnVal  = wrData[INTEN_BIT];
    strobe.rdWaitVal = wrData[RDWAIT_BIT];
    // set only when idle: a pending command ignores a repeated 1
    strobe.setDma    = wrEn && wrData[DMA_BIT]    && !cmdState.dma;
    strobe.setIrqRsp = wrEn && wrData[IRQRSP_BIT] && !cmdState.irqRsp;
    strobe.setAbort  = wrEn && wrData[ABORT_BIT]  && !cmdState.abort;
    strobe.setCcsd   = wrEn && wrData[CCSD_BIT]   && !cmdState.ccsd;
    // completion only counts while the command is pending
    strobe.clrIrqRsp = cmdState.irqRsp && irqRespDone;
    strobe.clrAbort  = cmdState.abort  && dataIdle;
    strobe.clrCcsd   = cmdState.ccsd   && ccsdSent;
  end
endmodule

// File: rtl/hcCtrlRegFile.sv
module hcCtrlRegFile
  import hcCtrlPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_INT  = 4,
  parameter int DMA_HOLD = 2,
  parameter int CCSD_DLY = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic               cardClkEn,
  input  logic [NUM_INT-1:0] intPending,
  input  logic [NUM_INT-1:0] intUnmask,
  output cmdStateT           cmdState,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               dmaRstOut,
  output logic               readWaitOut,
  output logic               irqRespReq,
  output logic               abortReq,
  output logic               ccsdDrive,
  output logic               cmdDoneSet
);
  localparam int DW = $clog2(DMA_HOLD + 1);
  localparam int CW = $clog2(CCSD_DLY + 1);

  logic          intEn, rdWait, dmaBit, irqRspBit, abortBit, ccsdBit;
  logic [DW-1:0] dmaCnt;
  logic [CW-1:0] tickCnt;
  logic          driveQ, doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn  <= 1'b0;
      rdWait <= 1'b0;
    end else if (strobe.lvlWr) begin
      intEn  <= strobe.intEnVal;
      rdWait <= strobe.rdWaitVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaBit <= 1'b0;
      dmaCnt <= '0;
    end else if (strobe.setDma) begin
      dmaBit <= 1'b1;
      dmaCnt <= DW'(DMA_HOLD);
    end else if (dmaBit) begin
      if (dmaCnt == DW'(1)) dmaBit <= 1'b0;
      dmaCnt <= dmaCnt - DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqRspBit <= 1'b0;
      abortBit  <= 1'b0;
    end else begin
      if (strobe.setIrqRsp)      irqRspBit <= 1'b1;
      else if (strobe.clrIrqRsp) irqRspBit <= 1'b0;
      if (strobe.setAbort)       abortBit  <= 1'b1;
      else if (strobe.clrAbort)  abortBit  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccsdBit <= 1'b0;
      tickCnt <= '0;
      driveQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.setCcsd) begin
        ccsdBit <= 1'b1;
        tickCnt <= '0;
        driveQ  <= 1'b0;
      end else if (strobe.clrCcsd) begin
        ccsdBit <= 1'b0;
        driveQ  <= 1'b0;
        doneQ   <= 1'b1;
      end else if (ccsdBit && cardClkEn && !driveQ) begin
        tickCnt <= tickCnt + CW'(1);
        if (tickCnt == CW'(CCSD_DLY - 1)) driveQ <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData             = '0;
    rdData[DMA_BIT]    = dmaBit;
    rdData[INTEN_BIT]  = intEn;
    rdData[RDWAIT_BIT] = rdWait;
    rdData[IRQRSP_BIT] = irqRspBit;
    rdData[ABORT_BIT]  = abortBit;
    rdData[CCSD_BIT]   = ccsdBit;
  end

  assign cmdState    = '{dma: dmaBit, irqRsp: irqRspBit, abort: abortBit, ccsd: ccsdBit};
  assign irqOut      = intEn && |(intPending & intUnmask);
  assign dmaRstOut   = dmaBit;
  assign readWaitOut = rdWait;
  assign irqRespReq  = irqRspBit;
  assign abortReq    = abortBit;
  assign ccsdDrive   = driveQ;
  assign cmdDoneSet  = doneQ;
endmodule

// File: rtl/hcCtrlReg.sv
module hcCtrlReg
  import hcCtrlPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_INT  = 4,
  parameter int DMA_HOLD = 2,
  parameter int CCSD_DLY = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_INT-1:0] intPending,
  input  logic [NUM_INT-1:0] intUnmask,
  output logic               irqOut,
  output logic               dmaRstOut,
  output logic               readWaitOut,
  output logic               irqRespReq,
  input  logic               irqRespDone,
  output logic               abortReq,
  input  logic               dataIdle,
  input  logic               cardClkEn,
  output logic               ccsdDrive,
  input  logic               ccsdSent,
  output logic               cmdDoneSet
);
  ctrlStrobeT strobe;
  cmdStateT   cmdState;

  hcCtrlDecode #(.DATA_W(DATA_W)) u_decode (
    .wrEn(wrEn), .wrData(wrData), .cmdState(cmdState),
    .irqRespDone(irqRespDone), .dataIdle(dataIdle), .ccsdSent(ccsdSent),
    .strobe(strobe)
  );

  hcCtrlRegFile #(.DATA_W(DATA_W), .NUM_INT(NUM_INT), .DMA_HOLD(DMA_HOLD),
                  .CCSD_DLY(CCSD_DLY)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cardClkEn(cardClkEn),
    .intPending(intPending), .intUnmask(intUnmask), .cmdState(cmdState),
    .rdData(rdData), .irqOut(irqOut), .dmaRstOut(dmaRstOut),
    .readWaitOut(readWaitOut), .irqRespReq(irqRespReq), .abortReq(abortReq),
    .ccsdDrive(ccsdDrive), .cmdDoneSet(cmdDoneSet)
  );
endmodule

// File: rtl/hcCtrlRegChk.sv
module hcCtrlRegChk
  import hcCtrlPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_INT = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_INT-1:0] intPending,
  input logic [NUM_INT-1:0] intUnmask,
  input logic               irqOut,
  input logic               dmaRstOut,
  input logic               irqRespDone,
  input logic               dataIdle,
  input logic               ccsdSent,
  input logic               ccsdDrive,
  input logic               cmdDoneSet
);
  a_r2_dma_min_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaRstOut) |=> dmaRstOut);
  a_r2_dma_max_two: assert property (@(posedge clk) disable iff (!rstN)
    dmaRstOut && $past(dmaRstOut) |=> !dmaRstOut);
  a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rdData[INTEN_BIT] && (|(intPending & intUnmask)));
  a_r5_rsp_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdData[IRQRSP_BIT] && irqRespDone |=> !rdData[IRQRSP_BIT]);
  a_r9_rsp_holds: assert property (@(posedge clk) disable iff (!rstN)
    rdData[IRQRSP_BIT] && !irqRespDone |=> rdData[IRQRSP_BIT]);
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdData[ABORT_BIT] && dataIdle |=> !rdData[ABORT_BIT]);
  a_r7_ccsd_done: assert property (@(posedge clk) disable iff (!rstN)
    rdData[CCSD_BIT] && ccsdSent |=> cmdDoneSet && !rdData[CCSD_BIT]);
  a_r8_drive_while_set: assert property (@(posedge clk) disable iff (!rstN)
    ccsdDrive |-> rdData[CCSD_BIT]);
  a_r11_no_stray_done: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[CCSD_BIT] |=> !cmdDoneSet);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1:0] == 2'b00 && !rdData[3] && !rdData[5]);
endmodule

bind hcCtrlReg hcCtrlRegChk #(.DATA_W(DATA_W), .NUM_INT(NUM_INT)) u_chk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .intPending(intPending),
  .intUnmask(intUnmask), .irqOut(irqOut), .dmaRstOut(dmaRstOut),
  .irqRespDone(irqRespDone), .dataIdle(dataIdle), .ccsdSent(ccsdSent),
  .ccsdDrive(ccsdDrive), .cmdDoneSet(cmdDoneSet)
);

// File: tb/hcCtrlReg_tb.sv
module hcCtrlReg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic [3:0]  intPending, intUnmask;
  logic        irqOut, dmaRstOut, readWaitOut, irqRespReq, irqRespDone;
  logic        abortReq, dataIdle, cardClkEn, ccsdDrive, ccsdSent, cmdDoneSet;

  typedef struct {
    logic [15:0] rd;
    logic [6:0]  outs;
    string       tag;
  } expT;
  expT expQ[$];

  int nChecks = 0;
  int nFail   = 0;
  bit running = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hcCtrlReg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .intPending(intPending), .intUnmask(intUnmask), .irqOut(irqOut),
    .dmaRstOut(dmaRstOut), .readWaitOut(readWaitOut), .irqRespReq(irqRespReq),
    .irqRespDone(irqRespDone), .abortReq(abortReq), .dataIdle(dataIdle),
    .cardClkEn(cardClkEn), .ccsdDrive(ccsdDrive), .ccsdSent(ccsdSent),
    .cmdDoneSet(cmdDoneSet)
  );

  // outs = {cmdDoneSet, ccsdDrive, abortReq, irqRespReq, readWaitOut, dmaRstOut, irqOut}
  task automatic cyc(input logic [15:0] eRd, input logic [6:0] eOut, input string tag);
    @(posedge clk);
    expQ.push_back('{rd: eRd, outs: eOut, tag: tag});
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; irqRespDone = 1'b0;
    dataIdle = 1'b0; ccsdSent = 1'b0; cardClkEn = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1;
    wrData = d;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0) begin
        expT e;
        logic [6:0] act;
        e = expQ.pop_front();
        act = {cmdDoneSet, ccsdDrive, abortReq, irqRespReq, readWaitOut, dmaRstOut, irqOut};
        nChecks++;
        if (rdData !== e.rd || act !== e.outs) begin
          nFail++;
          $display("FAIL %s: rd=%h outs=%b expected rd=%h outs=%b",
                   e.tag, rdData, act, e.rd, e.outs);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (running) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; intPending = '0; intUnmask = '0;
    irqRespDone = 1'b0; dataIdle = 1'b0; cardClkEn = 1'b0; ccsdSent = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(16'h0000, 7'b0000000, "R1 reset state");
    // levels and reserved bits
    wr(16'h0068); cyc(16'h0040, 7'b0000100, "R4/R10 read-wait set, reserved dropped");
    cyc(16'h0040, 7'b0000100, "R4 level holds");
    wr(16'h002B); cyc(16'h0000, 7'b0000000, "R4/R10 cleared, reserved read 0");
    // interrupt combine
    intPending = 4'b0011; intUnmask = 4'b0100;
    wr(16'h0010); cyc(16'h0010, 7'b0000000, "R3 all pending masked");
    intUnmask = 4'b0110; cyc(16'h0010, 7'b0000001, "R3 unmasked pending");
    wr(16'h0000); cyc(16'h0000, 7'b0000000, "R3 global enable off");
    intPending = '0;
    // DMA reset hold
    wr(16'h0004); cyc(16'h0004, 7'b0000010, "R2 cycle one");
    cyc(16'h0004, 7'b0000010, "R2 cycle two");
    cyc(16'h0000, 7'b0000000, "R2 self-cleared");
    wr(16'h0004); cyc(16'h0004, 7'b0000010, "R9 dma set");
    wr(16'h0004); cyc(16'h0004, 7'b0000010, "R9 rewrite while pending");
    cyc(16'h0000, 7'b0000000, "R9 no restart of hold");
    // interrupt response
    wr(16'h0080); cyc(16'h0080, 7'b0001000, "R5 set");
    wr(16'h0000); cyc(16'h0080, 7'b0001000, "R9 write zero no change");
    irqRespDone = 1'b1; cyc(16'h0000, 7'b0000000, "R5 cleared by done");
    irqRespDone = 1'b1; cyc(16'h0000, 7'b0000000, "R11 stray response done");
    // abort
    wr(16'h0100); cyc(16'h0100, 7'b0010000, "R6 set");
    cyc(16'h0100, 7'b0010000, "R6 holds while busy");
    dataIdle = 1'b1; cyc(16'h0000, 7'b0000000, "R6 cleared by idle");
    dataIdle = 1'b1; cyc(16'h0000, 7'b0000000, "R11 stray idle");
    // completion-signal-disable
    wr(16'h0200); cyc(16'h0200, 7'b0000000, "R7 set");
    cardClkEn = 1'b1; cyc(16'h0200, 7'b0000000, "R8 first tick");
    cyc(16'h0200, 7'b0000000, "R8 no tick");
    cardClkEn = 1'b1; cyc(16'h0200, 7'b0100000, "R8 drive after second tick");
    cardClkEn = 1'b1; cyc(16'h0200, 7'b0100000, "R8 drive holds");
    ccsdSent = 1'b1; cyc(16'h0000, 7'b1000000, "R7 cleared posts done");
    cyc(16'h0000, 7'b0000000, "R7 done pulse one cycle");
    ccsdSent = 1'b1; cyc(16'h0000, 7'b0000000, "R11 stray sent");
    @(posedge clk);
    #2;
    running = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule